// File: doc/BRIEF.md
# Reset Domain Controller

This block turns the board-level reset and halt pads, plus a reset request from the processor core, into separate reset domains for a small microcontroller-style system. It tells a full cold reset apart from a software-driven peripheral reset. A cold reset needs the reset pad and the halt pad low together. It clears the processor, the chip-select and port setup, the interrupt setup and the on-chip peripherals. A peripheral reset is requested by the core. The block then pulls the bidirectional reset pad low for a fixed number of clocks, which resets the external devices and the internal peripherals only.

The block also produces the tri-state controls for the external bus pins during each kind of reset and during external bus ownership. It forces the four active-low chip selects inactive during a cold reset. It latches a strap pin that selects the data-bus width for chip select 0. The pad levels pass through a synchronizer before the cold-reset condition is evaluated. Every reset output and pin control comes from a flip-flop. A synchronous active-high power-on input `rst` acts as a cold reset.

Top module: `rst_domain_ctrl`

## Requirements
- R1: A cold reset is detected only while `rst_pad_n_i` and `halt_n_i` are both low. Either pad low on its own resets nothing. With the default `SYNC_STAGES`=2, the reset outputs rise on the third rising clock edge after both pads go low.
- R2: During a cold reset, `cpu_rst`, `cfg_rst`, `irq_cfg_rst` and `periph_rst` are all high. They all fall on the third rising edge after either pad returns high.
- R3: When `sw_rst_req` is sampled high while no pulse is running and no cold reset is present, `rst_pad_oe` and `periph_rst` go high on that edge. They stay high for exactly `SW_RST_CYCLES` clocks (default 124). During the pulse, `cpu_rst`, `cfg_rst` and `irq_cfg_rst` stay low.
- R4: A `sw_rst_req` that arrives while a pulse is running is ignored. The pulse still ends at its original time.
- R5: During a cold reset, `addr_oe`, `data_oe`, `ctrl_oe` and `dstb_oe` are 0 (pins tri-stated) and `cs_force_high` is 1.
- R6: During a peripheral reset, `addr_oe`, `data_oe` and `ctrl_oe` stay 1 and `cs_force_high` stays 0.
- R7: One edge after `ext_master` is sampled high, `dstb_oe` is 0. The address, data and control enables are not affected by `ext_master`.
- R8: `mux_oe` (drive enable for the latch-enable, read and write strobes of the 8-bit multiplexed peripheral bus) is always 1, including during a cold reset and during external bus ownership.
- R9: `cs0_wide` takes `bus_width_strap` on the edge where the cold reset ends (0 = 8-bit, 1 = 16-bit data bus for chip select 0). It then holds that value. A peripheral reset does not resample the strap.
- R10: While `rst` is high, the block is in cold reset and `cs0_wide` is 0. On the first edge with `rst` low and both pads high, every reset output falls and the strap is captured.
- R11: A cold reset that occurs during a peripheral-reset pulse ends the pulse at once: `rst_pad_oe` is 0 while the cold reset is present. The pulse does not resume after the cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset, treated as a cold reset |
| rst_pad_n_i | input | 1 | Level seen on the bidirectional reset pad, active low |
| halt_n_i | input | 1 | Halt pad, active low |
| sw_rst_req | input | 1 | Peripheral-reset request from the processor core |
| ext_master | input | 1 | High while an external master owns the bus |
| bus_width_strap | input | 1 | Width strap for chip select 0 |
| rst_pad_oe | output | 1 | Drive the reset pad low when 1 |
| cpu_rst | output | 1 | Processor reset |
| cfg_rst | output | 1 | Chip-select and port configuration reset |
| irq_cfg_rst | output | 1 | Interrupt configuration reset |
| periph_rst | output | 1 | On-chip peripheral reset |
| addr_oe | output | 1 | Address pin drive enable |
| data_oe | output | 1 | Data pin drive enable |
| ctrl_oe | output | 1 | Address strobe and read/write pin drive enable |
| dstb_oe | output | 1 | Upper and lower data strobe drive enable |
| cs_force_high | output | 1 | Force all four chip selects inactive (high) |
| mux_oe | output | 1 | Multiplexed-bus strobe drive enable |
| cs0_wide | output | 1 | Latched width for chip select 0, 1 = 16-bit |

## Verification
The bench builds the block with `SW_RST_CYCLES`=20 and the default `SYNC_STAGES`=2. The shorter pulse keeps the start, the last cycle and the first idle cycle of a peripheral reset within a few dozen clocks. This makes room for a retrigger in the middle of the pulse and for a cold reset that cuts a pulse short. The bench derives its latencies from the synchronizer depth. Each edge of the cold-reset window is therefore sampled on the cycle before and the cycle of the change.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  // Drive enables of the external bus pin groups, 1 = drive
  typedef struct packed {
    logic addr;
    logic data;
    logic ctrl;
    logic dstb;
  } bus_oe_t;
endpackage

// File: rtl/rdc_sync.sv
module rdc_sync #(
  parameter int               STAGES = 2,
  parameter int               WIDTH  = 1,
  parameter logic [WIDTH-1:0] IDLE   = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= {STAGES{IDLE}};
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rdc_sw_timer.sv
module rdc_sw_timer #(
  parameter int CYCLES = 124
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic req,
  output logic active,
  output logic active_nxt
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    if (abort)             cnt_nxt = '0;
    else if (cnt != '0)    cnt_nxt = cnt - 1'b1;
    else if (req)          cnt_nxt = CW'(CYCLES);
    else                   cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  assign active     = (cnt != '0);
  assign active_nxt = (cnt_nxt != '0);
endmodule

// File: rtl/rdc_pin_ctrl.sv
module rdc_pin_ctrl
  import rdc_pkg::*;
(
  input  logic    clk,
  input  logic    cold_nxt,
  input  logic    ext_master,
  output bus_oe_t oe,
  output logic    cs_high
);
  // cold_nxt already carries the power-on reset, so no separate reset branch
  always_ff @(posedge clk) begin
    oe.addr <= ~cold_nxt;
    oe.data <= ~cold_nxt;
    oe.ctrl <= ~cold_nxt;
    oe.dstb <= ~cold_nxt & ~ext_master;
    cs_high <= cold_nxt;
  end
endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
  import rdc_pkg::*;
#(
  parameter int SW_RST_CYCLES = 124,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_pad_n_i,
  input  logic halt_n_i,
  input  logic sw_rst_req,
  input  logic ext_master,
  input  logic bus_width_strap,
  output logic rst_pad_oe,
  output logic cpu_rst,
  output logic cfg_rst,
  output logic irq_cfg_rst,
  output logic periph_rst,
  output logic addr_oe,
  output logic data_oe,
  output logic ctrl_oe,
  output logic dstb_oe,
  output logic cs_force_high,
  output logic mux_oe,
  output logic cs0_wide
);
  localparam int PADS = 2;

  logic [PADS-1:0] pad_s;
  logic            cold_nxt;
  logic            cold_q;
  logic            sw_on;
  logic            sw_nxt;
  logic            periph_q;
  logic            wide_q;
  bus_oe_t         bus_oe;

  // Pad levels enter the clock domain before being combined
  rdc_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (PADS),
    .IDLE  ({PADS{1'b1}})
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({rst_pad_n_i, halt_n_i}),
    .q  (pad_s)
  );

  // Cold reset: both pads low together, or power-on reset
  assign cold_nxt = rst | (pad_s == '0);

  rdc_sw_timer #(
    .CYCLES(SW_RST_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .abort     (cold_nxt),
    .req       (sw_rst_req),
    .active    (sw_on),
    .active_nxt(sw_nxt)
  );

  rdc_pin_ctrl u_pins (
    .clk       (clk),
    .cold_nxt  (cold_nxt),
    .ext_master(ext_master),
    .oe        (bus_oe),
    .cs_high   (cs_force_high)
  );

  always_ff @(posedge clk) begin
    cold_q   <= cold_nxt;
    periph_q <= cold_nxt | sw_nxt;
  end

  // Strap captured on the edge that ends a cold reset
  always_ff @(posedge clk) begin
    if (rst)                     wide_q <= 1'b0;
    else if (cold_q && !cold_nxt) wide_q <= bus_width_strap;
  end

  assign rst_pad_oe  = sw_on;
  assign cpu_rst     = cold_q;
  assign cfg_rst     = cold_q;
  assign irq_cfg_rst = cold_q;
  assign periph_rst  = periph_q;
  assign addr_oe     = bus_oe.addr;
  assign data_oe     = bus_oe.data;
  assign ctrl_oe     = bus_oe.ctrl;
  assign dstb_oe     = bus_oe.dstb;
  assign mux_oe      = 1'b1;
  assign cs0_wide    = wide_q;
endmodule

// File: rtl/rdc_checks.sv
module rdc_checks (
  input logic clk,
  input logic rst,
  input logic ext_master,
  input logic rst_pad_oe,
  input logic cpu_rst,
  input logic cfg_rst,
  input logic irq_cfg_rst,
  input logic periph_rst,
  input logic addr_oe,
  input logic data_oe,
  input logic ctrl_oe,
  input logic dstb_oe,
  input logic cs_force_high,
  input logic cs0_wide
);
  // R5
  cold_pins_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rst |-> (cs_force_high && !addr_oe && !data_oe && !ctrl_oe && !dstb_oe));

  // R3
  sw_scope_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pad_oe |-> (periph_rst && !cpu_rst && !cfg_rst && !irq_cfg_rst));

  // R6
  sw_pins_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pad_oe |-> (addr_oe && data_oe && ctrl_oe && !cs_force_high));

  // R7
  ext_dstb_chk: assert property (@(posedge clk) disable iff (rst)
    ext_master |=> !dstb_oe);

  // R2
  domain_cover_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rst |-> periph_rst);

  // R9
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rst |=> $stable(cs0_wide));

  // R3
  pulse_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pad_oe) |=> rst_pad_oe);
endmodule

bind rst_domain_ctrl rdc_checks u_rdc_checks (
  .clk          (clk),
  .rst          (rst),
  .ext_master   (ext_master),
  .rst_pad_oe   (rst_pad_oe),
  .cpu_rst      (cpu_rst),
  .cfg_rst      (cfg_rst),
  .irq_cfg_rst  (irq_cfg_rst),
  .periph_rst   (periph_rst),
  .addr_oe      (addr_oe),
  .data_oe      (data_oe),
  .ctrl_oe      (ctrl_oe),
  .dstb_oe      (dstb_oe),
  .cs_force_high(cs_force_high),
  .cs0_wide     (cs0_wide)
);

// File: tb/test_rst_domain_ctrl.sv
module test_rst_domain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SW_CYC     = 20;
  localparam int STAGES     = 2;
  localparam int LAT        = STAGES + 1;
  localparam int WD_CYCLES  = 20000;

  // {ext_pad_n, halt_n, ext_master, cpu_rst, periph_rst, addr_oe, dstb_oe, cs_force_high, mux_oe}
  localparam logic [8:0] VEC_TAB [8] = '{
    9'b110_001101,
    9'b111_001001,
    9'b010_001101,
    9'b011_001001,
    9'b100_001101,
    9'b000_110011,
    9'b001_110011,
    9'b101_001001
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pad_n = 1'b1;
  logic halt_n = 1'b1;
  logic sw_rst_req = 1'b0;
  logic ext_master = 1'b0;
  logic strap = 1'b1;
  logic pad_in;
  logic rst_pad_oe, cpu_rst, cfg_rst, irq_cfg_rst, periph_rst;
  logic addr_oe, data_oe, ctrl_oe, dstb_oe, cs_force_high, mux_oe, cs0_wide;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Open-drain pad: pulled low by the board or by the block
  assign pad_in = ext_pad_n & ~rst_pad_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_domain_ctrl #(
    .SW_RST_CYCLES(SW_CYC),
    .SYNC_STAGES  (STAGES)
  ) i_rst_domain_ctrl (
    .clk            (clk),
    .rst            (rst),
    .rst_pad_n_i    (pad_in),
    .halt_n_i       (halt_n),
    .sw_rst_req     (sw_rst_req),
    .ext_master     (ext_master),
    .bus_width_strap(strap),
    .rst_pad_oe     (rst_pad_oe),
    .cpu_rst        (cpu_rst),
    .cfg_rst        (cfg_rst),
    .irq_cfg_rst    (irq_cfg_rst),
    .periph_rst     (periph_rst),
    .addr_oe        (addr_oe),
    .data_oe        (data_oe),
    .ctrl_oe        (ctrl_oe),
    .dstb_oe        (dstb_oe),
    .cs_force_high  (cs_force_high),
    .mux_oe         (mux_oe),
    .cs0_wide       (cs0_wide)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    step(2);
    // R10 reset state
    chk("R10 reset domains", {cpu_rst, cfg_rst, irq_cfg_rst, periph_rst}, 4'b1111);
    chk("R10 reset pins", {addr_oe, data_oe, ctrl_oe, dstb_oe, cs_force_high}, 5'b00001);
    chk("R10 strap cleared", cs0_wide, 1'b0);
    chk("R10 pad idle", rst_pad_oe, 1'b0);
    chk("R8 mux in reset", mux_oe, 1'b1);
    rst = 1'b0;
    step(1);
    chk("R10 release", {cpu_rst, cfg_rst, irq_cfg_rst, periph_rst}, 4'b0000);
    chk("R9 strap on power-on exit", cs0_wide, 1'b1);

    // R1 R5 R7 R8 table of steady pad combinations
    for (int i = 0; i < 8; i++) begin
      {ext_pad_n, halt_n, ext_master} = VEC_TAB[i][8:6];
      step(LAT);
      chk($sformatf("R1 R5 R7 R8 vector %0d", i),
          {cpu_rst, periph_rst, addr_oe, dstb_oe, cs_force_high, mux_oe}, VEC_TAB[i][5:0]);
    end
    ext_pad_n = 1'b1; halt_n = 1'b1; ext_master = 1'b0;
    step(LAT);

    // R1 entry latency, R2 exit, R9 strap capture
    ext_pad_n = 1'b0; halt_n = 1'b0;
    step(LAT - 1);
    chk("R1 not before latency", cpu_rst, 1'b0);
    step(1);
    chk("R1 cold asserted", {cpu_rst, cfg_rst, irq_cfg_rst, periph_rst}, 4'b1111);
    strap = 1'b0;
    ext_pad_n = 1'b1; halt_n = 1'b1;
    step(LAT - 1);
    chk("R2 still held", cpu_rst, 1'b1);
    step(1);
    chk("R2 all released", {cpu_rst, cfg_rst, irq_cfg_rst, periph_rst}, 4'b0000);
    chk("R9 strap 8-bit", cs0_wide, 1'b0);
    strap = 1'b1;
    step(2);
    chk("R9 strap held", cs0_wide, 1'b0);

    // R3 R6 software pulse, R4 retrigger ignored
    sw_rst_req = 1'b1;
    step(1);
    sw_rst_req = 1'b0;
    chk("R3 pulse start", {rst_pad_oe, periph_rst}, 2'b11);
    chk("R3 core domains untouched", {cpu_rst, cfg_rst, irq_cfg_rst}, 3'b000);
    chk("R6 pins driven", {addr_oe, data_oe, ctrl_oe, dstb_oe, cs_force_high}, 5'b11110);
    step(4);
    sw_rst_req = 1'b1;
    step(1);
    sw_rst_req = 1'b0;
    step(SW_CYC - 6);
    chk("R3 last pulse cycle", {rst_pad_oe, periph_rst}, 2'b11);
    step(1);
    chk("R4 pulse not extended", {rst_pad_oe, periph_rst}, 2'b00);
    chk("R9 no resample on peripheral reset", cs0_wide, 1'b0);
    step(3);
    chk("R4 no restart", rst_pad_oe, 1'b0);

    // R11 cold reset cuts a pulse short
    sw_rst_req = 1'b1;
    step(1);
    sw_rst_req = 1'b0;
    chk("R11 pulse running", rst_pad_oe, 1'b1);
    ext_pad_n = 1'b0; halt_n = 1'b0;
    step(LAT);
    chk("R11 cold present", cpu_rst, 1'b1);
    chk("R11 pad released", rst_pad_oe, 1'b0);
    ext_pad_n = 1'b1; halt_n = 1'b1;
    step(LAT);
    chk("R11 cold ended", cpu_rst, 1'b0);
    chk("R11 pulse not resumed", {rst_pad_oe, periph_rst}, 2'b00);
    chk("R9 strap 16-bit", cs0_wide, 1'b1);

    // R7 external master timing
    ext_master = 1'b1;
    step(1);
    chk("R7 strobes released", dstb_oe, 1'b0);
    chk("R7 others driven", {addr_oe, data_oe, ctrl_oe, mux_oe}, 4'b1111);
    ext_master = 1'b0;
    step(1);
    chk("R7 strobes back", dstb_oe, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule